// File: doc/BRIEF.md
# Current-Output DAC Update Scheduler

This block is the digital front end of one 10-bit current-output DAC channel. Software reaches it over a byte-wide register bus that exposes three registers: a control register, a low data byte and a high data byte. Writes to the data bytes build a staged 10-bit code. The code that drives the converter input is a separate register. It is loaded from the staged word only when the selected update event occurs. That event is a write to the high data byte, a one-cycle timer overflow pulse, or a rising edge on an asynchronous trigger pin.

The control register also drives the channel enable and a 2-bit full-scale code to the analog stage. While the channel is enabled, the block signals that the pad belongs to the analog output and that the pad's digital driver and weak pull-up must be switched off. The converter, the bias source and the pad are outside this block and appear only as output signals.

Register addresses: 0 is control, 1 is the low data byte, 2 is the high data byte. Control byte layout: bit 7 is enable, bits 6:4 are the update mode, bits 1:0 are the full-scale code, and bits 3:2 read as zero.

Top module: `dac_sched_regif`

## Requirements
- R1: After reset, the committed code is 0 and the enable is 0. Control reads 0x70, meaning mode 111 and full-scale code 00, and both data bytes read 0x00.
- R2: A write to the low byte (address 1) stores only bits 7:6 of the written byte as code bits 1:0. It never changes the committed code. The low byte reads back as those two bits in positions 7:6, with bits 5:0 reading zero.
- R3: In mode 111, a write to the high byte (address 2) loads the committed code with {written byte, staged low bits}. The new code is visible after the same clock edge that samples the write.
- R4: In mode 111, after the low byte is preset once, each later high-byte write commits a new code built from that high byte and the same preset low bits.
- R5: In mode 100, a high-byte write only stages the value. A timer overflow pulse that is high at a clock edge commits the staged word at that edge.
- R6: In mode 101, the trigger pin passes through a two-flop synchronizer. Each rising edge commits the staged word exactly once, at the third clock edge after the pin is first sampled high. Holding the pin high, or letting it fall, commits nothing.
- R7: In any mode other than 111, 100 and 101, high-byte writes, timer pulses and pin edges leave the committed code unchanged.
- R8: The enable output, the pad-ownership output, the driver-disable output and the pull-up-disable output all equal the control enable bit (bit 7).
- R9: The full-scale field (control bits 1:0) uses 00 for 0.5 mA, 01 for 1 mA and 10 for 2 mA. A written 11 is stored and output as 10.
- R10: The high byte reads back as staged code bits 9:2. The control byte reads back in the layout above, with bits 3:2 always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 2 | Register address (0 control, 1 low data, 2 high data) |
| busWr | input | 1 | Write strobe, sampled on the rising clock edge |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr, combinational |
| timerOvf | input | 1 | One-cycle timer overflow pulse |
| extTrig | input | 1 | Asynchronous external trigger pin |
| dacCode | output | 10 | Committed code to the converter |
| dacEnable | output | 1 | Converter and bias enable |
| dacRange | output | 2 | Full-scale select code |
| padOwnDac | output | 1 | Pad is connected to the analog output |
| gpioDrvOff | output | 1 | Turn off the pad's digital driver |
| gpioPullOff | output | 1 | Turn off the pad's weak pull-up |

## Verification
The bench builds the block with its default parameters: a 10-bit code, an 8-bit bus and a two-stage synchronizer. With these values the left-justified split puts two code bits in the low byte, and the pin trigger lands on the third clock edge, so the bench can check the exact edge of a pin commit. The scoreboard records every change of the committed code and compares it with the expected sequence. This exposes any commit caused by a low-byte write, a staged-only write, a held pin or a disabled mode.

// File: rtl/dac_sched_pkg.sv
package dac_sched_pkg;
  localparam logic [1:0] ADDR_CTL  = 2'd0;
  localparam logic [1:0] ADDR_LOW  = 2'd1;
  localparam logic [1:0] ADDR_HIGH = 2'd2;

  localparam logic [2:0] MODE_DEMAND = 3'b111;
  localparam logic [2:0] MODE_TIMER  = 3'b100;
  localparam logic [2:0] MODE_PIN    = 3'b101;

  typedef struct packed {
    logic wrLow;
    logic wrHigh;
    logic commit;
    logic fromBus;
  } strobe_t;
endpackage

// File: rtl/dac_sched_ctrl.sv
module dac_sched_ctrl
  import dac_sched_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busAddr,
  input  logic       busWr,
  input  logic [7:0] busWrData,
  input  logic       timerOvf,
  input  logic       extTrig,
  output strobe_t    strobes,
  output logic       ctlEnable,
  output logic [1:0] ctlRange,
  output logic [7:0] ctlByte
);
  logic [2:0] ctlMode;
  logic [SYNC_STAGES:0] syncChain;
  logic extEdge;
  logic wrCtl;

  assign wrCtl = busWr && (busAddr == ADDR_CTL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlEnable <= 1'b0;
      ctlMode   <= MODE_DEMAND;
      ctlRange  <= 2'b00;
    end else if (wrCtl) begin
      ctlEnable <= busWrData[7];
      ctlMode   <= busWrData[6:4];
      ctlRange  <= (busWrData[1:0] == 2'b11) ? 2'b10 : busWrData[1:0];
    end
  end

  assign ctlByte = {ctlEnable, ctlMode, 2'b00, ctlRange};

  // Synchronizer chain plus one extra stage used for edge detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain[0] <= 1'b0;
    else       syncChain[0] <= extTrig;
  end

  for (genvar i = 1; i <= SYNC_STAGES; i++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncChain[i] <= 1'b0;
      else       syncChain[i] <= syncChain[i-1];
    end
  end

  assign extEdge = syncChain[SYNC_STAGES-1] && !syncChain[SYNC_STAGES];

  always_comb begin
    strobes.wrLow   = busWr && (busAddr == ADDR_LOW);
    strobes.wrHigh  = busWr && (busAddr == ADDR_HIGH);
    strobes.fromBus = (ctlMode == MODE_DEMAND) && strobes.wrHigh;
    strobes.commit  = strobes.fromBus
                   || ((ctlMode == MODE_TIMER) && timerOvf)
                   || ((ctlMode == MODE_PIN) && extEdge);
  end

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    extEdge |=> !extEdge); // R6
  AST_COMMIT_MODE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> (ctlMode == MODE_DEMAND || ctlMode == MODE_TIMER || ctlMode == MODE_PIN)); // R7
  AST_RANGE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    ctlRange != 2'b11); // R9
endmodule

// File: rtl/dac_sched_dpath.sv
module dac_sched_dpath
  import dac_sched_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [BUS_W-1:0]  busWrData,
  input  logic [1:0]        busAddr,
  input  logic [BUS_W-1:0]  ctlByte,
  output logic [BUS_W-1:0]  busRdData,
  output logic [DATA_W-1:0] dacCode
);
  localparam int LOW_W = DATA_W - BUS_W;
  localparam int PAD_W = BUS_W - LOW_W;

  logic [BUS_W-1:0] stagedHigh;
  logic [LOW_W-1:0] stagedLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stagedHigh <= '0;
      stagedLow  <= '0;
    end else begin
      if (strobes.wrLow)  stagedLow  <= busWrData[BUS_W-1 -: LOW_W];
      if (strobes.wrHigh) stagedHigh <= busWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dacCode <= '0;
    else if (strobes.commit) begin
      if (strobes.fromBus) dacCode <= {busWrData, stagedLow};
      else                 dacCode <= {stagedHigh, stagedLow};
    end
  end

  always_comb begin
    case (busAddr)
      ADDR_CTL:  busRdData = ctlByte;
      ADDR_LOW:  busRdData = {stagedLow, {PAD_W{1'b0}}};
      ADDR_HIGH: busRdData = stagedHigh;
      default:   busRdData = '0;
    endcase
  end

  AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wrLow && !strobes.commit) |=> $stable(dacCode)); // R2
  AST_DEMAND_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && strobes.fromBus) |=> (dacCode[DATA_W-1 -: BUS_W] == $past(busWrData))); // R3
endmodule

// File: rtl/dac_sched_regif.sv
module dac_sched_regif
  import dac_sched_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWr,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic              timerOvf,
  input  logic              extTrig,
  output logic [DATA_W-1:0] dacCode,
  output logic              dacEnable,
  output logic [1:0]        dacRange,
  output logic              padOwnDac,
  output logic              gpioDrvOff,
  output logic              gpioPullOff
);
  strobe_t strobes;
  logic [7:0] ctlByte;
  logic ctlEnable;

  dac_sched_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .timerOvf(timerOvf), .extTrig(extTrig),
    .strobes(strobes), .ctlEnable(ctlEnable), .ctlRange(dacRange),
    .ctlByte(ctlByte)
  );

  dac_sched_dpath #(.DATA_W(DATA_W), .BUS_W(8)) uDpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWrData(busWrData),
    .busAddr(busAddr), .ctlByte(ctlByte), .busRdData(busRdData),
    .dacCode(dacCode)
  );

  assign dacEnable   = ctlEnable;
  assign padOwnDac   = ctlEnable;
  assign gpioDrvOff  = ctlEnable;
  assign gpioPullOff = ctlEnable;
endmodule

// File: tb/sim_dac_sched_regif.sv
module sim_dac_sched_regif;
  logic clk = 0;
  logic rstN = 0;
  logic [1:0] busAddr = 0;
  logic busWr = 0;
  logic [7:0] busWrData = 0;
  logic [7:0] busRdData;
  logic timerOvf = 0;
  logic extTrig = 0;
  logic [9:0] dacCode;
  logic dacEnable, padOwnDac, gpioDrvOff, gpioPullOff;
  logic [1:0] dacRange;

  int nChecks = 0;
  int nFails = 0;
  logic [9:0] expQ[$];
  logic [9:0] prevCode = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dac_sched_regif u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busWrData(busWrData), .busRdData(busRdData), .timerOvf(timerOvf),
    .extTrig(extTrig), .dacCode(dacCode), .dacEnable(dacEnable),
    .dacRange(dacRange), .padOwnDac(padOwnDac), .gpioDrvOff(gpioDrvOff),
    .gpioPullOff(gpioPullOff)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1;
    @(negedge clk);
    busWr = 0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic pulseTimer();
    @(negedge clk);
    timerOvf = 1;
    @(negedge clk);
    timerOvf = 0;
  endtask

  task automatic expectCommit(input logic [9:0] v);
    expQ.push_back(v);
  endtask

  // Monitor: every change of the committed code must match the next expected item.
  always @(negedge clk) begin
    if (rstN && dacCode !== prevCode) begin
      if (expQ.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL scoreboard unexpected commit actual=0x%0h expected=none", dacCode);
      end else begin
        check("scoreboard commit", dacCode, expQ.pop_front());
      end
      prevCode = dacCode;
    end
  end

  initial begin
    #1600000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    check("R1 code", dacCode, 0);
    check("R1 enable", dacEnable, 0);
    rdReg(0, rd); check("R1 ctl", rd, 8'h70);
    rdReg(1, rd); check("R1 low", rd, 0);
    rdReg(2, rd); check("R1 high", rd, 0);
    check("R1 range", dacRange, 0);

    // R2 low byte stages only
    wrReg(1, 8'hFF);
    @(negedge clk); check("R2 code held", dacCode, 0);
    rdReg(1, rd); check("R2 low readback", rd, 8'hC0);

    // R3 on-demand commit on high write
    expectCommit(10'h297);
    wrReg(2, 8'hA5);
    check("R3 code", dacCode, 10'h297);
    rdReg(2, rd); check("R10 high readback", rd, 8'hA5);

    // R4 eight-bit usage
    wrReg(1, 8'h00);
    check("R4 low write no commit", dacCode, 10'h297);
    expectCommit(10'h040); wrReg(2, 8'h10);
    check("R4 first", dacCode, 10'h040);
    expectCommit(10'h044); wrReg(2, 8'h11);
    check("R4 second", dacCode, 10'h044);

    // R5 timer mode
    wrReg(0, 8'h40);
    wrReg(1, 8'h40);
    wrReg(2, 8'h3C);
    repeat (2) @(negedge clk);
    check("R5 high write staged only", dacCode, 10'h044);
    expectCommit(10'h0F1); pulseTimer();
    check("R5 timer commit", dacCode, 10'h0F1);
    wrReg(2, 8'h55);
    check("R5 staged again", dacCode, 10'h0F1);
    expectCommit(10'h155); pulseTimer();
    check("R5 second timer commit", dacCode, 10'h155);

    // R6 pin mode
    wrReg(0, 8'h50);
    wrReg(2, 8'h66);
    pulseTimer();
    check("R6 timer ignored in pin mode", dacCode, 10'h155);
    expectCommit(10'h199);
    @(negedge clk); extTrig = 1;
    repeat (2) @(negedge clk);
    check("R6 not before third edge", dacCode, 10'h155);
    @(negedge clk);
    check("R6 commit at third edge", dacCode, 10'h199);
    wrReg(2, 8'h77);
    repeat (8) @(negedge clk);
    check("R6 held pin no commit", dacCode, 10'h199);
    extTrig = 0;
    repeat (6) @(negedge clk);
    check("R6 falling no commit", dacCode, 10'h199);
    expectCommit(10'h1DD);
    extTrig = 1;
    repeat (4) @(negedge clk);
    check("R6 second edge", dacCode, 10'h1DD);
    extTrig = 0;
    repeat (4) @(negedge clk);

    // R7 other modes hold
    wrReg(0, 8'h00);
    wrReg(2, 8'h12);
    pulseTimer();
    extTrig = 1; repeat (5) @(negedge clk);
    extTrig = 0; repeat (5) @(negedge clk);
    wrReg(0, 8'h30);
    wrReg(2, 8'h13);
    pulseTimer();
    check("R7 code held", dacCode, 10'h1DD);

    // R8 enable and pad
    wrReg(0, 8'hF0);
    check("R8 enable", dacEnable, 1);
    check("R8 pad own", padOwnDac, 1);
    check("R8 drv off", gpioDrvOff, 1);
    check("R8 pull off", gpioPullOff, 1);
    check("R8 mode switch no commit", dacCode, 10'h1DD);

    // R9 range, R10 ctl readback
    wrReg(0, 8'hF3);
    check("R9 range 11->10", dacRange, 2'b10);
    rdReg(0, rd); check("R9 ctl readback", rd, 8'hF2);
    wrReg(0, 8'hF1);
    check("R9 range 01", dacRange, 2'b01);
    wrReg(0, 8'h7C);
    rdReg(0, rd); check("R10 ctl bits3:2 zero", rd, 8'h70);
    check("R8 disabled", padOwnDac, 0);

    repeat (3) @(negedge clk);
    check("scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule